// File: doc/BRIEF.md
# Processor-Port Trailing Tag Handler

This block sits on the switch port that faces the host processor and carries a single trailing tag byte on every frame crossing that port. Toward the processor (egress), each frame leaving the switch core is extended by one extra byte after its final data byte. That byte names, one-hot, the switch port the frame came from. From the processor (ingress), the final byte of each frame is the tag. The block removes it and hands its low nibble to the switch core as a destination port mask.

Both directions use byte-wide valid/ready streams with a `last` flag. A beat transfers on a clock edge where valid and ready are both high. A source that raises valid keeps it high, with data, last and side-band fields stable, until the beat transfers. Ready may be driven from the opposite side without delay.

Egress insertion adds one beat per frame, so input ready is held low while the tag beat waits. Ingress stripping holds each byte for one cycle, because a byte can only be known to be the frame's final data byte once the byte after it arrives. A single enable input selects tagged or plain operation. Each direction takes its mode from the enable value seen at the first beat of a frame.

Top module: `cpu_tailtag_port`

## Requirements
- R1: With tagging off, egress beats pass unchanged in data and last, one output beat per input beat.
- R2: With tagging on, egress data bytes pass in order with last cleared, followed by exactly one extra beat carrying last.
- R3: The inserted egress tag has bits [7:4] zero and bit k of [3:0] set for source port index k, the index being the one given with the frame's final input beat.
- R4: With tagging off, ingress beats pass unchanged, with destination mask 0 and drop flag 0.
- R5: With tagging on, an ingress frame of N>=2 bytes leaves as its first N-1 bytes in order, with last on byte N-1.
- R6: On the last ingress output beat, the destination mask equals bits [3:0] of the removed byte, and bits [7:4] of that byte have no effect. On all other beats the mask is 0.
- R7: When the removed byte's bits [3:0] are zero, the last ingress output beat carries drop=1 so the core discards the frame. Otherwise drop is 0.
- R8: With tagging on, a one-byte ingress frame produces no output beat.
- R9: The enable input is taken at the first beat of each frame and held for that frame. A change mid-frame affects only later frames.
- R10: An output beat whose valid is high and ready low stays valid with unchanged fields on the next cycle, and no byte is lost or duplicated under any ready/valid pattern.
- R11: After reset, both output valids are low and no byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_en | input | 1 | Trailing tag enable |
| eg_s_valid | input | 1 | Egress input beat valid (from switch core) |
| eg_s_ready | output | 1 | Egress input ready |
| eg_s_data | input | 8 | Egress input byte |
| eg_s_last | input | 1 | Egress input final byte of frame |
| eg_s_src | input | SRC_W (2) | Source port index, sampled with the last beat |
| eg_m_valid | output | 1 | Egress output valid (to processor) |
| eg_m_ready | input | 1 | Egress output ready |
| eg_m_data | output | 8 | Egress output byte |
| eg_m_last | output | 1 | Egress output final byte |
| ig_s_valid | input | 1 | Ingress input valid (from processor) |
| ig_s_ready | output | 1 | Ingress input ready |
| ig_s_data | input | 8 | Ingress input byte |
| ig_s_last | input | 1 | Ingress input final byte (the tag when enabled) |
| ig_m_valid | output | 1 | Ingress output valid (to switch core) |
| ig_m_ready | input | 1 | Ingress output ready |
| ig_m_data | output | 8 | Ingress output byte |
| ig_m_last | output | 1 | Ingress output final byte |
| ig_m_dest | output | 4 | Destination port mask, on the last beat |
| ig_m_drop | output | 1 | Discard-frame flag, on the last beat |

## Verification
Egress is tried with frames of one, two and five bytes from every source index. The one-byte case shows that the tag follows even a lone byte, and the sweep over indices separates the one-hot encodings. Ingress is tried with tag bytes whose upper nibble is set, which shows that those bits are ignored, and with a zero low nibble, which separates drop from a normal destination. It is also tried with one-byte frames, which must vanish without disturbing the next frame. Random ready and valid gaps on both sides show that the held byte and the tag beat survive stalls. Flipping the enable in the middle of a frame shows that the mode is taken only at frame starts.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic {EG_PASS, EG_TAG} eg_state_t;

  function automatic logic [BYTE_W-1:0] tag_byte(input logic [NIB_W-1:0] ports);
    return {{(BYTE_W-NIB_W){1'b0}}, ports};
  endfunction
endpackage

// File: rtl/tt_frame_mode.sv
module tt_frame_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic beat_fire,
  input  logic beat_last,
  output logic mode
);
  logic busy;
  logic held;

  assign mode = busy ? held : cfg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      held <= 1'b0;
    end else if (beat_fire) begin
      if (beat_last) begin
        busy <= 1'b0;
      end else if (!busy) begin
        busy <= 1'b1;
        held <= cfg_en;
      end
    end
  end
endmodule

// File: rtl/tt_egress_insert.sv
module tt_egress_insert
  import tt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int SRC_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  input  logic [SRC_W-1:0]  s_src,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  output logic              tag_phase
);
  eg_state_t        state;
  logic [SRC_W-1:0] src_q;
  logic [NIB_W-1:0] port_bits;

  always_comb begin
    port_bits = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (src_q == SRC_W'(i)) port_bits[i] = 1'b1;
    end
  end

  always_comb begin
    if (state == EG_TAG) begin
      m_valid = 1'b1;
      m_data  = tag_byte(port_bits);
      m_last  = 1'b1;
      s_ready = 1'b0;
    end else begin
      m_valid = s_valid;
      m_data  = s_data;
      m_last  = s_last & ~mode;
      s_ready = m_ready;
    end
  end

  assign tag_phase = (state == EG_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= EG_PASS;
      src_q <= '0;
    end else begin
      case (state)
        EG_PASS: if (s_valid && s_ready && s_last && mode) begin
          state <= EG_TAG;
          src_q <= s_src;
        end
        EG_TAG: if (m_ready) state <= EG_PASS;
        default: state <= EG_PASS;
      endcase
    end
  end
endmodule

// File: rtl/tt_ingress_strip.sv
module tt_ingress_strip
  import tt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  output logic [NIB_W-1:0]  m_dest,
  output logic              m_drop
);
  logic              hold_v;
  logic [BYTE_W-1:0] hold_d;
  logic              pair_ok;

  assign pair_ok = hold_v & s_valid;

  always_comb begin
    if (mode) begin
      m_valid = pair_ok;
      m_data  = hold_d;
      m_last  = s_last;
      m_dest  = s_last ? s_data[NIB_W-1:0] : '0;
      m_drop  = pair_ok & s_last & (s_data[NIB_W-1:0] == '0);
      s_ready = ~hold_v | m_ready;
    end else begin
      m_valid = s_valid;
      m_data  = s_data;
      m_last  = s_last;
      m_dest  = '0;
      m_drop  = 1'b0;
      s_ready = m_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (mode && s_valid && s_ready) begin
      hold_v <= ~s_last;
      hold_d <= s_data;
    end
  end
endmodule

// File: rtl/cpu_tailtag_port.sv
module cpu_tailtag_port
  import tt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int SRC_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en,
  input  logic              eg_s_valid,
  output logic              eg_s_ready,
  input  logic [BYTE_W-1:0] eg_s_data,
  input  logic              eg_s_last,
  input  logic [SRC_W-1:0]  eg_s_src,
  output logic              eg_m_valid,
  input  logic              eg_m_ready,
  output logic [BYTE_W-1:0] eg_m_data,
  output logic              eg_m_last,
  input  logic              ig_s_valid,
  output logic              ig_s_ready,
  input  logic [BYTE_W-1:0] ig_s_data,
  input  logic              ig_s_last,
  output logic              ig_m_valid,
  input  logic              ig_m_ready,
  output logic [BYTE_W-1:0] ig_m_data,
  output logic              ig_m_last,
  output logic [NIB_W-1:0]  ig_m_dest,
  output logic              ig_m_drop
);
  logic eg_mode, ig_mode;
  logic eg_fire, ig_fire;
  logic eg_tag_phase;

  assign eg_fire = eg_s_valid & eg_s_ready;
  assign ig_fire = ig_s_valid & ig_s_ready;

  tt_frame_mode u_eg_mode (
    .clk(clk), .rst_n(rst_n), .cfg_en(tag_en),
    .beat_fire(eg_fire), .beat_last(eg_s_last), .mode(eg_mode)
  );

  tt_frame_mode u_ig_mode (
    .clk(clk), .rst_n(rst_n), .cfg_en(tag_en),
    .beat_fire(ig_fire), .beat_last(ig_s_last), .mode(ig_mode)
  );

  tt_egress_insert #(.NUM_PORTS(NUM_PORTS)) u_eg (
    .clk(clk), .rst_n(rst_n), .mode(eg_mode),
    .s_valid(eg_s_valid), .s_ready(eg_s_ready), .s_data(eg_s_data),
    .s_last(eg_s_last), .s_src(eg_s_src),
    .m_valid(eg_m_valid), .m_ready(eg_m_ready), .m_data(eg_m_data),
    .m_last(eg_m_last), .tag_phase(eg_tag_phase)
  );

  tt_ingress_strip u_ig (
    .clk(clk), .rst_n(rst_n), .mode(ig_mode),
    .s_valid(ig_s_valid), .s_ready(ig_s_ready), .s_data(ig_s_data),
    .s_last(ig_s_last),
    .m_valid(ig_m_valid), .m_ready(ig_m_ready), .m_data(ig_m_data),
    .m_last(ig_m_last), .m_dest(ig_m_dest), .m_drop(ig_m_drop)
  );
endmodule

// File: rtl/tt_tailtag_checker.sv
module tt_tailtag_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       eg_m_valid,
  input logic       eg_m_ready,
  input logic [7:0] eg_m_data,
  input logic       eg_m_last,
  input logic       eg_tag_phase,
  input logic       ig_m_valid,
  input logic       ig_m_ready,
  input logic [7:0] ig_m_data,
  input logic       ig_m_last,
  input logic [3:0] ig_m_dest,
  input logic       ig_m_drop
);
  // R10: stalled egress beat held (input side obeys the same rule)
  a_r10_eg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eg_m_valid && !eg_m_ready |=> eg_m_valid && $stable(eg_m_data) && $stable(eg_m_last));

  // R10: stalled ingress beat held
  a_r10_ig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ig_m_valid && !ig_m_ready |=> ig_m_valid && $stable(ig_m_data) && $stable(ig_m_last)
      && $stable(ig_m_dest) && $stable(ig_m_drop));

  // R3: tag beat form
  a_r3_tag_form: assert property (@(posedge clk) disable iff (!rst_n)
    eg_tag_phase |-> eg_m_valid && eg_m_last && eg_m_data[7:4] == 4'd0
      && $onehot(eg_m_data[3:0]));

  // R2: a completed tag beat ends the tag phase
  a_r2_one_tag: assert property (@(posedge clk) disable iff (!rst_n)
    eg_tag_phase && eg_m_ready |=> !eg_tag_phase);

  // R6: mask only on the last beat
  a_r6_dest_last_only: assert property (@(posedge clk) disable iff (!rst_n)
    ig_m_valid && !ig_m_last |-> ig_m_dest == 4'd0);

  // R7: drop only on a last beat with no destination
  a_r7_drop_form: assert property (@(posedge clk) disable iff (!rst_n)
    ig_m_drop |-> ig_m_valid && ig_m_last && ig_m_dest == 4'd0);
endmodule

bind cpu_tailtag_port tt_tailtag_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .eg_m_valid(eg_m_valid), .eg_m_ready(eg_m_ready), .eg_m_data(eg_m_data),
  .eg_m_last(eg_m_last), .eg_tag_phase(eg_tag_phase),
  .ig_m_valid(ig_m_valid), .ig_m_ready(ig_m_ready), .ig_m_data(ig_m_data),
  .ig_m_last(ig_m_last), .ig_m_dest(ig_m_dest), .ig_m_drop(ig_m_drop)
);

// File: tb/cpu_tailtag_port_test.sv
module cpu_tailtag_port_test;
  typedef struct packed {logic [7:0] d; logic l; logic [1:0] s;} beat_t;
  typedef struct packed {logic [7:0] d; logic l; logic [3:0] m; logic x;} obs_t;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tag_en = 1'b0;
  logic eg_s_valid = 1'b0, eg_s_last = 1'b0, eg_m_ready = 1'b1;
  logic [7:0] eg_s_data = '0;
  logic [1:0] eg_s_src = '0;
  logic ig_s_valid = 1'b0, ig_s_last = 1'b0, ig_m_ready = 1'b1;
  logic [7:0] ig_s_data = '0;
  logic eg_s_ready, eg_m_valid, eg_m_last, ig_s_ready, ig_m_valid, ig_m_last, ig_m_drop;
  logic [7:0] eg_m_data, ig_m_data;
  logic [3:0] ig_m_dest;

  cpu_tailtag_port uut (
    .clk(clk), .rst_n(rst_n), .tag_en(tag_en),
    .eg_s_valid(eg_s_valid), .eg_s_ready(eg_s_ready), .eg_s_data(eg_s_data),
    .eg_s_last(eg_s_last), .eg_s_src(eg_s_src),
    .eg_m_valid(eg_m_valid), .eg_m_ready(eg_m_ready), .eg_m_data(eg_m_data),
    .eg_m_last(eg_m_last),
    .ig_s_valid(ig_s_valid), .ig_s_ready(ig_s_ready), .ig_s_data(ig_s_data),
    .ig_s_last(ig_s_last),
    .ig_m_valid(ig_m_valid), .ig_m_ready(ig_m_ready), .ig_m_data(ig_m_data),
    .ig_m_last(ig_m_last), .ig_m_dest(ig_m_dest), .ig_m_drop(ig_m_drop)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic eg_fired = 1'b0, ig_fired = 1'b0;
  beat_t eg_q[$];
  beat_t ig_q[$];
  obs_t eg_got[$], eg_exp[$], ig_got[$], ig_exp[$];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  // drivers: all inputs change 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (eg_fired) void'(eg_q.pop_front());
    if (!(eg_s_valid && !eg_fired)) begin
      if (rst_n && eg_q.size() > 0 && (!bp || lfsr[3])) begin
        eg_s_valid = 1'b1; eg_s_data = eg_q[0].d; eg_s_last = eg_q[0].l; eg_s_src = eg_q[0].s;
      end else eg_s_valid = 1'b0;
    end
    if (ig_fired) void'(ig_q.pop_front());
    if (!(ig_s_valid && !ig_fired)) begin
      if (rst_n && ig_q.size() > 0 && (!bp || lfsr[7])) begin
        ig_s_valid = 1'b1; ig_s_data = ig_q[0].d; ig_s_last = ig_q[0].l;
      end else ig_s_valid = 1'b0;
    end
    eg_m_ready = !bp || lfsr[1];
    ig_m_ready = !bp || lfsr[5];
  end

  // monitors: sample at the falling edge
  always @(negedge clk) begin
    eg_fired = eg_s_valid && eg_s_ready;
    ig_fired = ig_s_valid && ig_s_ready;
    if (rst_n && eg_m_valid && eg_m_ready) eg_got.push_back({eg_m_data, eg_m_last, 4'd0, 1'b0});
    if (rst_n && ig_m_valid && ig_m_ready) ig_got.push_back({ig_m_data, ig_m_last, ig_m_dest, ig_m_drop});
  end

  task automatic check1(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic eg_frame(bq_t b, logic [1:0] src, logic en);
    for (int i = 0; i < b.size(); i++) begin
      eg_q.push_back({b[i], i == b.size() - 1, src});
      eg_exp.push_back({b[i], (i == b.size() - 1) && !en, 4'd0, 1'b0});
    end
    if (en) eg_exp.push_back({8'(4'b0001 << src), 1'b1, 4'd0, 1'b0});
  endtask

  task automatic ig_frame(bq_t b, logic en);
    int n = b.size();
    for (int i = 0; i < n; i++) ig_q.push_back({b[i], i == n - 1, 2'd0});
    if (!en) begin
      for (int i = 0; i < n; i++) ig_exp.push_back({b[i], i == n - 1, 4'd0, 1'b0});
    end else if (n >= 2) begin
      for (int i = 0; i < n - 1; i++)
        ig_exp.push_back({b[i], i == n - 2, (i == n - 2) ? b[n-1][3:0] : 4'd0,
                          (i == n - 2) && (b[n-1][3:0] == 4'd0)});
    end
  endtask

  task automatic drain();
    while (eg_q.size() > 0 || ig_q.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic compare(string req);
    check1(req, "egress beat count", eg_got.size(), eg_exp.size());
    for (int i = 0; i < eg_got.size() && i < eg_exp.size(); i++)
      check1(req, $sformatf("egress beat %0d", i), 32'(eg_got[i]), 32'(eg_exp[i]));
    check1(req, "ingress beat count", ig_got.size(), ig_exp.size());
    for (int i = 0; i < ig_got.size() && i < ig_exp.size(); i++)
      check1(req, $sformatf("ingress beat %0d", i), 32'(ig_got[i]), 32'(ig_exp[i]));
    eg_got.delete(); eg_exp.delete(); ig_got.delete(); ig_exp.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check1("R11", "egress valid after reset", eg_m_valid, 1'b0);
    check1("R11", "ingress valid after reset", ig_m_valid, 1'b0);
    check1("R11", "ingress ready after reset", ig_s_ready, 1'b1);
  endtask

  task automatic t_eg_bypass();
    tag_en = 1'b0;
    eg_frame('{8'h11, 8'h22, 8'h33}, 2'd2, 1'b0);
    eg_frame('{8'h44}, 2'd1, 1'b0);
    drain(); compare("R1");
  endtask

  task automatic t_eg_tag();
    tag_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      eg_frame('{8'hA0 + 8'(s)}, 2'(s), 1'b1);
      eg_frame('{8'h50, 8'h51}, 2'(s), 1'b1);
      eg_frame('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, 2'(s), 1'b1);
    end
    drain(); compare("R2/R3");
  endtask

  task automatic t_ig_bypass();
    tag_en = 1'b0;
    ig_frame('{8'hDE, 8'hAD, 8'hF3}, 1'b0);
    ig_frame('{8'h07}, 1'b0);
    drain(); compare("R4");
  endtask

  task automatic t_ig_strip();
    tag_en = 1'b1;
    ig_frame('{8'h10, 8'h20, 8'h30, 8'hF2}, 1'b1);
    ig_frame('{8'h99, 8'h01}, 1'b1);
    ig_frame('{8'h61, 8'h62, 8'hAC}, 1'b1);
    drain(); compare("R5/R6");
  endtask

  task automatic t_ig_drop();
    tag_en = 1'b1;
    ig_frame('{8'h55, 8'h66, 8'h30}, 1'b1);
    ig_frame('{8'h77, 8'h04}, 1'b1);
    drain(); compare("R7");
  endtask

  task automatic t_ig_single();
    tag_en = 1'b1;
    ig_frame('{8'h08}, 1'b1);
    ig_frame('{8'hC1, 8'hC2, 8'h05}, 1'b1);
    drain(); compare("R8");
  endtask

  task automatic t_mode_switch();
    tag_en = 1'b1;
    eg_frame('{8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26}, 2'd3, 1'b1);
    ig_frame('{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h09}, 1'b1);
    while (eg_got.size() < 1 || ig_got.size() < 1) @(negedge clk);
    tag_en = 1'b0;
    drain();
    eg_frame('{8'h41, 8'h42}, 2'd1, 1'b0);
    ig_frame('{8'h51, 8'h52}, 1'b0);
    drain(); compare("R9");
  endtask

  task automatic t_backpressure();
    bp = 1'b1;
    tag_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      eg_frame('{8'(k), 8'(k + 16), 8'(k + 32)}, 2'(k), 1'b1);
      ig_frame('{8'(k + 64), 8'(k + 80), 8'(k + 96), 8'(8'hE0 | (k + 1))}, 1'b1);
      ig_frame('{8'hEE}, 1'b1);
    end
    drain(); compare("R10");
    bp = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_eg_bypass();
    t_eg_tag();
    t_ig_bypass();
    t_ig_strip();
    t_ig_drop();
    t_ig_single();
    t_mode_switch();
    t_backpressure();
    summary();
    $finish;
  end
endmodule